// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a memory-mapped watchdog built on a 64-bit up-counter. The counter is reached as two 32-bit halves, and it is compared against a 64-bit period that is also stored as two halves. A plain 32-bit register port gives access to the counter, the period, a run-control register, a global-control register and a watchdog-control register. Software first loads the period and the run settings. It then arms the watchdog by writing two 16-bit keys in a fixed order into the upper half of the watchdog-control register. After that it keeps the system alive by repeating the same two-key sequence, which clears the counter.

The key logic is a four-state machine. ST_IDLE goes to ST_PREARM on the opening key when the enable bit is set. ST_PREARM goes to ST_ARMED on the closing key. ST_ARMED goes to ST_SVC on the opening key. ST_SVC goes back to ST_ARMED on the closing key, and that return is the keep-alive. Any other key leaves the state unchanged. Once the block leaves ST_IDLE, every configuration write is dropped. Only the key field and the flag-clear bit still have an effect. If the counter reaches the period while the block is in ST_ARMED or ST_SVC, the block emits a one-cycle reset pulse, sets a sticky flag and restarts counting from zero.

Top module: `kwdt_top`

## Requirements
- R1: After reset, every register reads zero except the identity word at byte offset 0x00, which reads the ID_VALUE parameter. The reset output is low and the key state is ST_IDLE.
- R2: Byte offsets: 0x10 counter low, 0x14 counter high, 0x18 period low, 0x1C period high, 0x20 run control (bits 7:6 kept), 0x24 global control (bits 3:0 kept), 0x28 watchdog control. In the watchdog-control register, bit 14 is the enable bit, bit 15 is the flag and bits 31:16 are the key field, which reads zero. Offset 0x04 reads zero. In ST_IDLE every writable field reads back what was written.
- R3: The counter advances by one per cycle, carrying across the halves, only when global-control bits 0 and 1 are both 1, global-control bits 3:2 equal 2 and run-control bits 7:6 equal 2. Otherwise it holds.
- R4: Arming needs key 0xA5C6 written with bit 14 set (ST_IDLE to ST_PREARM), followed by key 0xDA7E (ST_PREARM to ST_ARMED).
- R5: In every state other than ST_IDLE, writes to the counter, the period, run control, global control and the enable bit are ignored.
- R6: In ST_ARMED, key 0xA5C6 enters ST_SVC and does not touch the counter. In ST_SVC, key 0xDA7E returns to ST_ARMED, and the counter reads zero in the cycle after the write is accepted.
- R7: A key other than the one the current state expects changes neither the state nor the counter.
- R8: In ST_ARMED or ST_SVC, a counter value equal to the period raises the reset output for exactly one cycle, starting on the next cycle. The counter restarts from zero, so pulses repeat every period+1 cycles without service.
- R9: The timeout sets the flag at bit 15. The flag stays set until a watchdog-control write with bit 15 equal to 1, or a reset. Writing 0 to bit 15 leaves it set, and the clear works in any state.
- R10: In ST_IDLE and ST_PREARM no reset pulse is produced, even when the running counter passes the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write when 1, read when 0 |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| wd_reset | output | 1 | One-cycle timeout reset pulse |

## Verification
The run condition is swept over all 16 global-control codes and all 4 run-control modes. Only one of the 64 combinations may count, which separates each qualifying bit from the others. The period is swept from 1 to 6, and the exact cycle of the first pulse and the spacing to the next pulse are measured. This separates a compare made on the wrong cycle, or a wrap to the wrong value, from correct behaviour. Key patterns cover the right keys, keys in the wrong order, a missing enable bit and stray values in each state. They are told apart by period readback before arming and by counter readback after arming.

// File: rtl/kwdt_pkg.sv
`timescale 1ns/1ps
package kwdt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PREARM = 2'd1,
        ST_ARMED  = 2'd2,
        ST_SVC    = 2'd3
    } wd_state_e;

    localparam int REG_W    = 32;
    localparam int KEY_W    = 16;
    localparam int KEY_LSB  = 16;
    localparam int EN_BIT   = 14;
    localparam int FLAG_BIT = 15;

    localparam logic [KEY_W-1:0] KEY_OPEN  = 16'hA5C6;
    localparam logic [KEY_W-1:0] KEY_CLOSE = 16'hDA7E;

    localparam int OFS_ID     = 'h00;
    localparam int OFS_EMU    = 'h04;
    localparam int OFS_CNT_LO = 'h10;
    localparam int OFS_CNT_HI = 'h14;
    localparam int OFS_PER_LO = 'h18;
    localparam int OFS_PER_HI = 'h1C;
    localparam int OFS_RCTL   = 'h20;
    localparam int OFS_GCTL   = 'h24;
    localparam int OFS_WCTL   = 'h28;

    localparam logic [1:0] RUN_CONT   = 2'd2;
    localparam logic [1:0] GMODE_WDOG = 2'd2;
endpackage

// File: rtl/kwdt_keyfsm.sv
`timescale 1ns/1ps
module kwdt_keyfsm
    import kwdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_val,
    input  logic             en_req,
    output logic             armed,
    output logic             locked,
    output logic             kick
);
    wd_state_e state_q, state_d;
    logic      kick_d;

    // next-state decode
    always_comb begin
        state_d = state_q;
        kick_d  = 1'b0;
        if (key_wr) begin
            unique case (state_q)
                ST_IDLE:   if (key_val == KEY_OPEN && en_req) state_d = ST_PREARM;
                ST_PREARM: if (key_val == KEY_CLOSE)          state_d = ST_ARMED;
                ST_ARMED:  if (key_val == KEY_OPEN)           state_d = ST_SVC;
                ST_SVC: begin
                    if (key_val == KEY_CLOSE) begin
                        state_d = ST_ARMED;
                        kick_d  = 1'b1;
                    end
                end
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            locked <= 1'b0;
            kick   <= 1'b0;
        end else begin
            armed  <= (state_d == ST_ARMED) || (state_d == ST_SVC);
            locked <= (state_d != ST_IDLE);
            kick   <= kick_d;
        end
    end
endmodule

// File: rtl/kwdt_counter.sv
`timescale 1ns/1ps
module kwdt_counter #(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                armed,
    input  logic                kick,
    input  logic [1:0]          half_ld,
    input  logic [HALF_W-1:0]   ld_data,
    input  logic [2*HALF_W-1:0] period,
    output logic [2*HALF_W-1:0] cnt,
    output logic                tmo_evt,
    output logic                tmo_pulse
);
    localparam int CNT_W = 2 * HALF_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_ld;

    // per-half load merge
    for (genvar h = 0; h < 2; h++) begin : g_half
        assign cnt_ld[h*HALF_W +: HALF_W] = half_ld[h] ? ld_data
                                                       : cnt_q[h*HALF_W +: HALF_W];
    end

    assign tmo_evt = run && armed && (cnt_q == period);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            tmo_pulse <= 1'b0;
        end else begin
            tmo_pulse <= tmo_evt;
            if (kick)          cnt_q <= '0;
            else if (|half_ld) cnt_q <= cnt_ld;
            else if (tmo_evt)  cnt_q <= '0;
            else if (run)      cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/kwdt_regs.sv
`timescale 1ns/1ps
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int          ADDR_W   = 6,
    parameter logic [31:0] ID_VALUE = 32'h5744_0107
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic               locked,
    input  logic [2*REG_W-1:0] cnt,
    input  logic               tmo_evt,
    output logic [2*REG_W-1:0] period,
    output logic               run,
    output logic [1:0]         half_ld,
    output logic [REG_W-1:0]   ld_data,
    output logic               key_wr,
    output logic [KEY_W-1:0]   key_val,
    output logic               en_req
);
    logic [2*REG_W-1:0] per_q;
    logic [1:0]         rctl_q;
    logic [3:0]         gctl_q;
    logic               en_q, flag_q;
    logic               wr_en, cfg_wr, flag_clr;

    function automatic logic at(input logic [ADDR_W-1:0] a, input int ofs);
        return a == ADDR_W'(ofs);
    endfunction

    assign wr_en    = bus_sel && bus_wr;
    assign cfg_wr   = wr_en && !locked;
    assign flag_clr = wr_en && at(bus_addr, OFS_WCTL) && bus_wdata[FLAG_BIT];

    assign key_wr     = wr_en && at(bus_addr, OFS_WCTL);
    assign key_val    = bus_wdata[KEY_LSB +: KEY_W];
    assign en_req     = bus_wdata[EN_BIT];
    assign half_ld[0] = cfg_wr && at(bus_addr, OFS_CNT_LO);
    assign half_ld[1] = cfg_wr && at(bus_addr, OFS_CNT_HI);
    assign ld_data    = bus_wdata;

    assign run    = gctl_q[0] && gctl_q[1] && (gctl_q[3:2] == GMODE_WDOG)
                 && (rctl_q == RUN_CONT);
    assign period = per_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q  <= '0;
            rctl_q <= '0;
            gctl_q <= '0;
            en_q   <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (cfg_wr && at(bus_addr, OFS_PER_LO)) per_q[REG_W-1:0]       <= bus_wdata;
            if (cfg_wr && at(bus_addr, OFS_PER_HI)) per_q[2*REG_W-1:REG_W] <= bus_wdata;
            if (cfg_wr && at(bus_addr, OFS_RCTL))   rctl_q <= bus_wdata[7:6];
            if (cfg_wr && at(bus_addr, OFS_GCTL))   gctl_q <= bus_wdata[3:0];
            if (cfg_wr && at(bus_addr, OFS_WCTL))   en_q   <= bus_wdata[EN_BIT];
            if (tmo_evt)       flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_ID):     bus_rdata = ID_VALUE;
            ADDR_W'(OFS_EMU):    bus_rdata = '0;
            ADDR_W'(OFS_CNT_LO): bus_rdata = cnt[REG_W-1:0];
            ADDR_W'(OFS_CNT_HI): bus_rdata = cnt[2*REG_W-1:REG_W];
            ADDR_W'(OFS_PER_LO): bus_rdata = per_q[REG_W-1:0];
            ADDR_W'(OFS_PER_HI): bus_rdata = per_q[2*REG_W-1:REG_W];
            ADDR_W'(OFS_RCTL):   bus_rdata = {24'b0, rctl_q, 6'b0};
            ADDR_W'(OFS_GCTL):   bus_rdata = {28'b0, gctl_q};
            ADDR_W'(OFS_WCTL):   bus_rdata = {16'b0, flag_q, en_q, 14'b0};
            default:             bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/kwdt_top.sv
`timescale 1ns/1ps
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int          ADDR_W   = 6,
    parameter logic [31:0] ID_VALUE = 32'h5744_0107
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wd_reset
);
    logic [2*REG_W-1:0] cnt, period;
    logic               run, armed, locked, kick, tmo_evt;
    logic [1:0]         half_ld;
    logic [REG_W-1:0]   ld_data;
    logic               key_wr, en_req;
    logic [KEY_W-1:0]   key_val;

    kwdt_regs #(.ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .locked(locked), .cnt(cnt), .tmo_evt(tmo_evt),
        .period(period), .run(run), .half_ld(half_ld), .ld_data(ld_data),
        .key_wr(key_wr), .key_val(key_val), .en_req(en_req)
    );

    kwdt_keyfsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .key_wr(key_wr), .key_val(key_val), .en_req(en_req),
        .armed(armed), .locked(locked), .kick(kick)
    );

    kwdt_counter #(.HALF_W(REG_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .run(run), .armed(armed), .kick(kick),
        .half_ld(half_ld), .ld_data(ld_data), .period(period),
        .cnt(cnt), .tmo_evt(tmo_evt), .tmo_pulse(wd_reset)
    );
endmodule

// File: rtl/kwdt_chk.sv
`timescale 1ns/1ps
module kwdt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        armed,
    input logic        locked,
    input logic        kick,
    input logic [63:0] cnt,
    input logic [63:0] period,
    input logic        wd_reset
);
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_reset && period != '0) |=> !wd_reset);

    a_r6_kick_zero: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt == '0));

    a_r5_period_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(period));

    a_r10_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !wd_reset);

    a_r4_two_step_arm: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> !armed);
endmodule

bind kwdt_top kwdt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .armed(armed), .locked(locked),
    .kick(kick), .cnt(cnt), .period(period), .wd_reset(wd_reset)
);

// File: tb/test_kwdt_top.sv
`timescale 1ns/1ps
module test_kwdt_top;
    localparam logic [31:0] ID_EXP = 32'h1234_ABCD;
    localparam logic [5:0] A_ID = 6'h00, A_EMU = 6'h04, A_CLO = 6'h10, A_CHI = 6'h14,
                           A_PLO = 6'h18, A_PHI = 6'h1C, A_RC = 6'h20, A_GC = 6'h24,
                           A_WC = 6'h28;
    localparam logic [15:0] K_OPEN = 16'hA5C6, K_CLOSE = 16'hDA7E;

    logic        clk = 1'b0, rst_n = 1'b0, sel = 1'b0, wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        wd_rst;
    int n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    kwdt_top #(.ADDR_W(6), .ID_VALUE(ID_EXP)) i_kwdt_top (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .wd_reset(wd_rst)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rreg(input logic [5:0] a, output logic [31:0] d);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        sel = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic setup_run(input logic [31:0] per, input logic [31:0] start);
        wreg(A_PLO, per); wreg(A_PHI, 32'h0);
        wreg(A_GC, 32'hB); wreg(A_RC, 32'h80);
        wreg(A_CHI, 32'h0); wreg(A_CLO, start);
    endtask

    task automatic arm();
        wreg(A_WC, {K_OPEN, 16'h4000});
        wreg(A_WC, {K_CLOSE, 16'h4000});
    endtask

    task automatic service();
        wreg(A_WC, {K_OPEN, 16'h0});
        wreg(A_WC, {K_CLOSE, 16'h0});
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        for (int i = 1; i <= 80; i++) begin
            @(negedge clk);
            if (wd_rst === 1'b1) begin n = i; break; end
        end
    endtask

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog (R1..): actual hung expected completion");
        finish_up();
    end

    initial begin
        logic [31:0] v, v1, v2;
        int n, k, pulses;
        logic first_low;

        // R1 reset values
        do_reset();
        rreg(A_ID, v);  check("R1 id", v, ID_EXP);
        rreg(A_EMU, v); check("R1 emu", v, 0);
        rreg(A_CLO, v); check("R1 cnt_lo", v, 0);
        rreg(A_CHI, v); check("R1 cnt_hi", v, 0);
        rreg(A_PLO, v); check("R1 per_lo", v, 0);
        rreg(A_PHI, v); check("R1 per_hi", v, 0);
        rreg(A_RC, v);  check("R1 rctl", v, 0);
        rreg(A_GC, v);  check("R1 gctl", v, 0);
        rreg(A_WC, v);  check("R1 wctl", v, 0);
        check("R1 wd_reset low", wd_rst, 0);

        // R2 readback in idle
        wreg(A_PLO, 32'h1234_5678); rreg(A_PLO, v); check("R2 per_lo", v, 32'h1234_5678);
        wreg(A_PHI, 32'h9ABC_DEF0); rreg(A_PHI, v); check("R2 per_hi", v, 32'h9ABC_DEF0);
        wreg(A_CLO, 32'h0000_0777); rreg(A_CLO, v); check("R2 cnt_lo", v, 32'h777);
        wreg(A_CHI, 32'h0000_0055); rreg(A_CHI, v); check("R2 cnt_hi", v, 32'h55);
        wreg(A_RC, 32'hFFFF_FFFF);  rreg(A_RC, v);  check("R2 rctl bits 7:6", v, 32'hC0);
        wreg(A_GC, 32'hFFFF_FFFF);  rreg(A_GC, v);  check("R2 gctl bits 3:0", v, 32'hF);
        wreg(A_WC, 32'hFFFF_4000);  rreg(A_WC, v);  check("R2 wctl en, key reads 0", v, 32'h4000);

        // R3 exhaustive run-condition sweep
        do_reset();
        for (int g = 0; g < 16; g++) begin
            for (int m = 0; m < 4; m++) begin
                wreg(A_GC, 32'(g));
                wreg(A_RC, 32'(m) << 6);
                wreg(A_CHI, 32'h0);
                wreg(A_CLO, 32'h0);
                repeat (3) @(negedge clk);
                rreg(A_CLO, v);
                check($sformatf("R3 gate g=%0d m=%0d", g, m), v, (g == 11 && m == 2) ? 3 : 0);
            end
        end
        // R3 carry between halves
        wreg(A_GC, 32'hB); wreg(A_RC, 32'h80);
        wreg(A_CHI, 32'h0); wreg(A_CLO, 32'hFFFF_FFFE);
        repeat (2) @(negedge clk);
        rreg(A_CHI, v1); rreg(A_CLO, v2);
        check("R3 carry hi", v1, 1);
        check("R3 carry lo", v2, 0);

        // R10 no pulse in idle or prearm
        do_reset();
        setup_run(32'd2, 32'd0);
        pulses = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (wd_rst) pulses++; end
        rreg(A_CLO, v);
        check("R10 idle counter passes period", v, 20);
        check("R10 idle pulses", pulses, 0);
        do_reset();
        setup_run(32'd40, 32'd0);
        wreg(A_WC, {K_OPEN, 16'h4000});
        pulses = 0;
        for (int i = 0; i < 50; i++) begin @(negedge clk); if (wd_rst) pulses++; end
        check("R10 prearm pulses", pulses, 0);

        // R4 / R5 / R7 arming and lock
        do_reset();
        setup_run(32'd1000, 32'd0);
        wreg(A_WC, {K_CLOSE, 16'h4000});
        wreg(A_PLO, 32'd1001); rreg(A_PLO, v); check("R7 closing key in idle ignored", v, 1001);
        wreg(A_WC, {K_OPEN, 16'h0000});
        wreg(A_PLO, 32'd1000); rreg(A_PLO, v); check("R4 opening key without enable ignored", v, 1000);
        wreg(A_WC, {K_OPEN, 16'h4000});
        wreg(A_PLO, 32'd7);    rreg(A_PLO, v); check("R5 period locked in prearm", v, 1000);
        wreg(A_WC, {K_OPEN, 16'h4000});
        wreg(A_WC, {K_CLOSE, 16'h4000});
        wreg(A_GC, 32'h0);     rreg(A_GC, v);  check("R5 gctl locked", v, 32'hB);
        wreg(A_RC, 32'h0);     rreg(A_RC, v);  check("R5 rctl locked", v, 32'h80);
        wreg(A_CHI, 32'h5);    rreg(A_CHI, v); check("R5 cnt_hi locked", v, 0);
        wreg(A_WC, 32'h0);     rreg(A_WC, v);  check("R5 enable bit locked", v, 32'h4000);

        // R6 / R7 keep-alive and stray keys
        service();
        @(negedge clk);
        rreg(A_CLO, v); check("R6 counter zero after keep-alive", v, 0);
        repeat (4) @(negedge clk);
        rreg(A_CLO, v); check("R6 counter resumes", v, 4);
        rreg(A_CLO, v1);
        wreg(A_WC, {K_CLOSE, 16'h0});
        rreg(A_CLO, v2); check("R7 closing key in armed no reload", v2, v1 + 2);
        rreg(A_CLO, v1);
        wreg(A_WC, {K_OPEN, 16'h0});
        rreg(A_CLO, v2); check("R6 opening key no reload", v2, v1 + 2);
        rreg(A_CLO, v1);
        wreg(A_WC, {16'h1234, 16'h0});
        rreg(A_CLO, v2); check("R7 stray key in service no reload", v2, v1 + 2);
        wreg(A_WC, {K_CLOSE, 16'h0});
        @(negedge clk);
        rreg(A_CLO, v); check("R6 service completes after stray key", v, 0);

        // R4 / R8 / R9 timeout timing sweep
        for (int p = 1; p <= 6; p++) begin
            do_reset();
            setup_run(32'(p), 32'd100);
            arm();
            service();
            wait_pulse(n);
            check($sformatf("R8 R4 first pulse p=%0d", p), n, p + 2);
            rreg(A_WC, v);
            check($sformatf("R9 flag set p=%0d", p), v[15], 1);
            k = 0; first_low = 1'b0;
            for (int i = 1; i <= 40; i++) begin
                @(negedge clk);
                if (i == 1) first_low = !wd_rst;
                if (wd_rst) begin k = i; break; end
            end
            check($sformatf("R8 one-cycle pulse p=%0d", p), first_low, 1);
            check($sformatf("R8 repeat spacing p=%0d", p), k, p + 1);
        end

        // R9 sticky flag and clear
        do_reset();
        setup_run(32'd20, 32'd100);
        arm();
        service();
        wait_pulse(n);
        check("R8 pulse p=20", n, 22);
        service();
        rreg(A_WC, v); check("R9 flag after service", v[15], 1);
        repeat (5) @(negedge clk);
        rreg(A_WC, v); check("R9 flag sticky", v[15], 1);
        wreg(A_WC, 32'h0);
        rreg(A_WC, v); check("R9 writing 0 keeps flag", v[15], 1);
        wreg(A_WC, 32'h0000_8000);
        rreg(A_WC, v); check("R9 W1C clears flag while armed", v[15], 0);
        check("R9 no pulse during clear", wd_rst, 0);
        wait_pulse(n);
        do_reset();
        rreg(A_WC, v); check("R9 R1 reset clears flag", v, 0);

        finish_up();
    end
endmodule